// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block is the message-signalled interrupt engine of a PCI function. It keeps a per-vector table, where each entry holds a 64-bit message address, a 32-bit message payload and a per-entry mask bit. It also keeps a pending-bit array. Software reaches both through a 32-bit little-endian register port. A select line chooses between the table region and the pending region. The capability's enable and mask-all bits arrive as level inputs from the configuration logic.

The device raises requests by vector index, and a separate per-vector in-use vector qualifies them. A request for an unmasked vector queues a memory-write message, which is presented on a valid/ready handshake. A request for a masked vector is recorded as pending. When a pending vector loses its mask, the controller clears the pending bit and queues the message by itself. This happens whether the mask was lifted by a table write or by a control change. When the control bits change and the function ends up enabled, the block pulses a request to drop the legacy line interrupt.

Top module: `msix_ctrl`

## Requirements
- R1: After reset every table entry reads zero except the control word, which reads 1 (mask set). All pending bits are zero and no message is offered.
- R2: A vector is treated as masked when its entry mask bit is set, or when the function mask is active. The function mask is active while enable is low or mask-all is high.
- R3: A request for an in-use vector that is masked sends nothing. It sets that vector's pending bit.
- R4: A request for an in-use, unmasked vector offers one message carrying that entry's 64-bit address and 32-bit payload. The message appears the cycle after the request and stays valid until msg_ready is seen.
- R5: When a vector with its pending bit set goes from masked to unmasked, the pending bit clears and a message is queued. A control change is evaluated on the edge that samples it. An entry-mask write is evaluated one cycle after the write commits.
- R6: The pending bit of vector v is bit v mod 32 of pending-region word v div 32, which is bit v mod 8 of byte v div 8. The region spans the vector count rounded up to 64 bits. Words outside it read zero.
- R7: Writes to the pending region change nothing.
- R8: Each table entry occupies 16 bytes. Address bits 31:0 are at byte offset 0, address bits 63:32 at 4, the payload at 8, and the control word at 12, with the mask in bit 0. The other control bits read zero. Read data is valid the cycle after the read access. An 8-byte access is issued as two 32-bit accesses.
- R9: A request whose index is not below the vector count, or whose vector is not in use, is dropped. It produces no message and no pending bit.
- R10: Taking a vector out of use clears its pending bit.
- R11: intx_clr pulses for one cycle, one cycle after the control bits change, when enable is high after the change. No pulse occurs when the change leaves enable low.
- R12: When several messages are queued, they are offered lowest vector index first, one per completed handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Capability enable bit |
| ctl_mask_all | input | 1 | Capability function-mask bit |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_pba | input | 1 | 1 = pending region, 0 = table region |
| reg_addr | input | REG_AW | Byte address within the region (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_idx | input | IDX_W | Requested vector index |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |
| intx_clr | output | 1 | Pulse to drop the legacy line interrupt |

## Verification
Two things can fall on the same vector in the same cycle: a fresh request, and the automatic replay of its pending bit when the mask lifts. The bench provokes this by raising enable and the request for an already-pending vector on one edge. It then expects exactly one message, a cleared pending bit, and no second message after the handshake. A similar overlap is tested when lifting mask-all releases two pending vectors in one edge. Here the bench expects both messages, in ascending index order.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } entry_word_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    function automatic int pba_words(input int nvec);
        return ((nvec + 63) / 64) * 2;
    endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int REG_AW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_word,
    output logic [NUM_VEC-1:0] mask_o,
    output vec_entry_t        entry_o [NUM_VEC]
);
    localparam int IW = REG_AW - 4;

    vec_entry_t  ent [NUM_VEC];
    logic [IW-1:0] idx;
    entry_word_e word;
    logic        hit;

    assign idx  = addr[REG_AW-1:4];
    assign word = entry_word_e'(addr[3:2]);
    assign hit  = (int'(idx) < NUM_VEC);

    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (rst) begin
                ent[v] <= '{addr: 64'd0, data: 32'd0, mask: 1'b1};
            end else if (wr_en && hit && idx == IW'(v)) begin
                case (word)
                    W_ADDR_LO: ent[v].addr[31:0]  <= wdata;
                    W_ADDR_HI: ent[v].addr[63:32] <= wdata;
                    W_DATA:    ent[v].data        <= wdata;
                    default:   ent[v].mask        <= wdata[0];
                endcase
            end
        end
    end

    always_comb begin
        rd_word = 32'd0;
        for (int v = 0; v < NUM_VEC; v++) begin
            mask_o[v]  = ent[v].mask;
            entry_o[v] = ent[v];
            if (hit && idx == IW'(v)) begin
                case (word)
                    W_ADDR_LO: rd_word = ent[v].addr[31:0];
                    W_ADDR_HI: rd_word = ent[v].addr[63:32];
                    W_DATA:    rd_word = ent[v].data;
                    default:   rd_word = {31'd0, ent[v].mask};
                endcase
            end
        end
    end

endmodule

// File: rtl/msix_pend_ctrl.sv
module msix_pend_ctrl #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] entry_mask,
    input  logic               func_mask,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [NUM_VEC-1:0] used,
    input  logic [NUM_VEC-1:0] grant,
    output logic [NUM_VEC-1:0] pending,
    output logic [NUM_VEC-1:0] fire
);
    logic [NUM_VEC-1:0] eff_mask, masked_q, used_q, pend_q, fire_q;
    logic [NUM_VEC-1:0] req_hit, replay, release_v;

    assign eff_mask = entry_mask | {NUM_VEC{func_mask}};

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            req_hit[v] = req_valid && (req_idx == IDX_W'(v)) && used[v];
        end
    end

    assign replay    = masked_q & ~eff_mask & pend_q;
    assign release_v = used_q & ~used;

    always_ff @(posedge clk) begin
        if (rst) begin
            masked_q <= '1;
            used_q   <= '0;
            pend_q   <= '0;
            fire_q   <= '0;
        end else begin
            masked_q <= eff_mask;
            used_q   <= used;
            pend_q   <= (pend_q & ~replay & ~release_v) | (req_hit & eff_mask);
            fire_q   <= (fire_q & ~grant) | (req_hit & ~eff_mask) | replay;
        end
    end

    assign pending = pend_q;
    assign fire    = fire_q;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
        AST_MASKED_REQ_PENDS: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_idx == IDX_W'(g) && used[g] && eff_mask[g]) |=> pend_q[g]) // R3
            else $error("masked request not pended");
        AST_REPLAY_ON_UNMASK: assert property (@(posedge clk) disable iff (rst)
            (masked_q[g] && !eff_mask[g] && pend_q[g]) |=> (!pend_q[g] && fire_q[g])) // R5
            else $error("pending vector not replayed");
        AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (used_q[g] && !used[g]) |=> !pend_q[g]) // R10
            else $error("released vector still pending");
    end

endmodule

// File: rtl/msix_msg_arb.sv
module msix_msg_arb
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] fire,
    input  logic               ready,
    input  vec_entry_t         entry_i [NUM_VEC],
    output logic               valid,
    output logic [63:0]        addr,
    output logic [31:0]        data,
    output logic [NUM_VEC-1:0] grant
);
    logic [NUM_VEC-1:0] pick;

    always_comb begin
        pick = '0;
        addr = 64'd0;
        data = 32'd0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (fire[v]) begin
                pick    = '0;
                pick[v] = 1'b1;
                addr    = entry_i[v].addr;
                data    = entry_i[v].data;
            end
        end
    end

    assign valid = |fire;
    assign grant = ready ? pick : '0;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) // R12
        else $error("more than one grant");
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> valid) // R4
        else $error("message withdrawn before acceptance");

endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 11,
    parameter int REG_AW  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_enable,
    input  logic               ctl_mask_all,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic               reg_pba,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               irq_valid,
    input  logic [IDX_W-1:0]   irq_idx,
    input  logic [NUM_VEC-1:0] vec_used,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic               intx_clr
);
    localparam int PBA_DW = pba_words(NUM_VEC);
    localparam int DW_AW  = REG_AW - 2;

    vec_entry_t         entries [NUM_VEC];
    logic [NUM_VEC-1:0] emask, pending, fire, grant;
    logic [31:0]        tbl_word, pba_word;
    logic [PBA_DW*32-1:0] pba_flat;
    logic [DW_AW-1:0]   dw_idx;
    logic [1:0]         ctl_q;
    logic               func_mask;

    assign func_mask = !ctl_enable || ctl_mask_all;

    msix_vec_table #(.NUM_VEC(NUM_VEC), .REG_AW(REG_AW)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(reg_en && reg_we && !reg_pba),
        .addr(reg_addr), .wdata(reg_wdata),
        .rd_word(tbl_word), .mask_o(emask), .entry_o(entries)
    );

    msix_pend_ctrl #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst(rst),
        .entry_mask(emask), .func_mask(func_mask),
        .req_valid(irq_valid), .req_idx(irq_idx), .used(vec_used),
        .grant(grant), .pending(pending), .fire(fire)
    );

    msix_msg_arb #(.NUM_VEC(NUM_VEC)) u_arb (
        .clk(clk), .rst(rst),
        .fire(fire), .ready(msg_ready), .entry_i(entries),
        .valid(msg_valid), .addr(msg_addr), .data(msg_data), .grant(grant)
    );

    assign dw_idx = reg_addr[REG_AW-1:2];

    always_comb begin
        pba_flat = '0;
        pba_flat[NUM_VEC-1:0] = pending;
        pba_word = 32'd0;
        for (int k = 0; k < PBA_DW; k++) begin
            if (dw_idx == DW_AW'(k)) pba_word = pba_flat[k*32 +: 32];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= 32'd0;
            ctl_q     <= 2'b00;
            intx_clr  <= 1'b0;
        end else begin
            if (reg_en && !reg_we) reg_rdata <= reg_pba ? pba_word : tbl_word;
            ctl_q    <= {ctl_mask_all, ctl_enable};
            intx_clr <= ({ctl_mask_all, ctl_enable} != ctl_q) && ctl_enable;
        end
    end

    AST_INTX_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        intx_clr |-> $past(ctl_enable)) // R11
        else $error("line-interrupt drop while disabled");
    AST_PBA_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_pba) |=> $stable(emask)) // R7
        else $error("pending-region write altered table");

endmodule

// File: tb/msix_ctrl_tb.sv
module msix_ctrl_tb_top;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_enable = 1'b0, ctl_mask_all = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0, reg_pba = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_valid = 1'b0;
    logic [10:0] irq_idx = '0;
    logic [NV-1:0] vec_used = '1;
    logic        msg_valid, msg_ready = 1'b0, intx_clr;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msix_ctrl #(.NUM_VEC(NV)) dut_i (
        .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_mask_all(ctl_mask_all),
        .reg_en(reg_en), .reg_we(reg_we), .reg_pba(reg_pba), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_idx(irq_idx), .vec_used(vec_used), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
        .intx_clr(intx_clr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit pba, input int a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_pba = pba; reg_addr = 16'(a); reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input bit pba, input int a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_pba = pba; reg_addr = 16'(a);
        @(negedge clk);
        reg_en = 0;
        d = reg_rdata;
    endtask

    task automatic req(input int idx);
        @(negedge clk);
        irq_valid = 1; irq_idx = 11'(idx);
        @(negedge clk);
        irq_valid = 0;
    endtask

    task automatic set_ctl(input bit en, input bit ma);
        @(negedge clk);
        ctl_enable = en; ctl_mask_all = ma;
        @(negedge clk);
    endtask

    task automatic take(input string tag, input int v);
        chk({tag, " valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " addr"}, msg_addr, {32'(v), 32'hFEE0_0000 | 32'(v << 4)});
        chk({tag, " data"}, 64'(msg_data), 64'(32'h100 + v));
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 no message", 64'(msg_valid), 0);
        rd(0, 12, d); chk("R1 ctrl mask set", 64'(d), 1);
        rd(0, 16*7 + 8, d); chk("R1 data zero", 64'(d), 0);
        rd(1, 0, d); chk("R1 pending zero", 64'(d), 0);
    endtask

    task automatic t_program();
        logic [31:0] d;
        for (int v = 0; v < NV; v++) begin
            wr(0, 16*v, 32'hFEE0_0000 | 32'(v << 4));
            wr(0, 16*v + 4, 32'(v));
            wr(0, 16*v + 8, 32'h100 + 32'(v));
        end
        rd(0, 32, d);     chk("R8 addr lo", 64'(d), 64'hFEE0_0020);
        rd(0, 36, d);     chk("R8 addr hi", 64'(d), 2);
        rd(0, 40, d);     chk("R8 data", 64'(d), 64'h102);
        wr(0, 44, 32'hFFFF_FFFE);
        rd(0, 44, d);     chk("R8 ctrl cleared", 64'(d), 0);
        wr(0, 44, 32'hFFFF_FFFF);
        rd(0, 44, d);     chk("R8 ctrl other bits zero", 64'(d), 1);
    endtask

    task automatic t_enable_and_mask();
        logic [31:0] d;
        set_ctl(1, 0);
        chk("R11 pulse on enable", 64'(intx_clr), 1);
        @(negedge clk);
        chk("R11 single cycle", 64'(intx_clr), 0);
        req(3);
        chk("R3 masked sends nothing", 64'(msg_valid), 0);
        rd(1, 0, d); chk("R3 R6 pending bit3", 64'(d), 64'h08);
        wr(0, 16*3 + 12, 0);
        chk("R5 not before eval cycle", 64'(msg_valid), 0);
        @(negedge clk);
        rd(1, 0, d); chk("R5 pending cleared", 64'(d), 0);
        repeat (3) @(negedge clk);
        take("R5 R4 replay held", 3);
        chk("R4 one message", 64'(msg_valid), 0);
        req(3);
        take("R4 direct", 3);
        chk("R4 drained", 64'(msg_valid), 0);
    endtask

    task automatic t_pba_inert();
        logic [31:0] d;
        req(5);
        wr(1, 0, 32'hFFFF_FFFF);
        wr(1, 0, 32'h0);
        rd(1, 0, d); chk("R7 write ignored", 64'(d), 64'h20);
        rd(1, 4, d); chk("R6 upper word", 64'(d), 0);
        rd(1, 8, d); chk("R6 outside region", 64'(d), 0);
    endtask

    task automatic t_func_mask();
        logic [31:0] d;
        set_ctl(1, 1);
        chk("R11 pulse on mask-all", 64'(intx_clr), 1);
        wr(0, 16*5 + 12, 0);
        @(negedge clk);
        chk("R2 function mask holds", 64'(msg_valid), 0);
        req(3);
        chk("R2 request under mask-all", 64'(msg_valid), 0);
        rd(1, 0, d); chk("R2 both pending", 64'(d), 64'h28);
        set_ctl(1, 0);
        take("R12 lowest first", 3);
        take("R12 next", 5);
        chk("R12 drained", 64'(msg_valid), 0);
        rd(1, 0, d); chk("R5 pending cleared by control", 64'(d), 0);
    endtask

    task automatic t_drop_release();
        logic [31:0] d;
        req(9);
        chk("R9 out of range", 64'(msg_valid), 0);
        @(negedge clk); vec_used[3] = 0;
        req(3);
        chk("R9 unused vector", 64'(msg_valid), 0);
        rd(1, 0, d); chk("R9 no pending", 64'(d), 0);
        vec_used[3] = 1;
        req(6);
        rd(1, 0, d); chk("R10 set before release", 64'(d), 64'h40);
        @(negedge clk); vec_used[6] = 0;
        @(negedge clk);
        rd(1, 0, d); chk("R10 cleared by release", 64'(d), 0);
        vec_used[6] = 1;
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        set_ctl(0, 0);
        chk("R11 no pulse when disabled", 64'(intx_clr), 0);
        req(3);
        rd(1, 0, d); chk("R2 disabled pends", 64'(d), 64'h08);
        @(negedge clk);
        ctl_enable = 1; irq_valid = 1; irq_idx = 11'd3;
        @(negedge clk);
        irq_valid = 0;
        chk("R11 pulse re-enable", 64'(intx_clr), 1);
        take("R5 R4 coincident", 3);
        chk("R5 single coincident message", 64'(msg_valid), 0);
        rd(1, 0, d); chk("R5 coincident pending clear", 64'(d), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_program();
        t_enable_and_mask();
        t_pba_inert();
        t_func_mask();
        t_drop_release();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule